// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block drives a byte-level I2C master engine that can move no more than four bytes per command. A client hands it one message: a length, a direction, a flag saying whether another message follows under a repeated START, and a target address that is either 7 or 10 bits wide. The sequencer checks the request, forms the address bytes the engine sends, and then cuts the message into bursts. Each burst goes to the engine as one command. The command carries the byte count minus one. It also carries a hold-the-bus flag on every burst except the last. On the last burst it carries a repeated-START flag when the message is part of a combined transfer.

After each command the sequencer waits for the engine's response. For writes, it asks the external data buffer to load a burst before that burst's command goes out. For reads, it asks the buffer to take the bytes once a burst has completed cleanly. An engine error stops the message at once. If the engine moves fewer bytes than asked, the message fails, and the sequencer sends an abort command unless the bus is already being released. The buffer and the bit-level bus timing are outside this block.

Top module: `i2c_chunk_seq`

## Requirements
- R1: The block rejects a request whose length is 0, whose address exceeds 0x3FF, or whose address exceeds 0x7F in 7-bit mode. It reports `done` with `status` = 1 (bad request) and issues no command and no buffer strobe.
- R2: A message of length L is issued as (L+3)/4 commands. Every command carries 4 bytes except the last, which carries the remainder. `cmd_cnt` holds the byte count minus 1.
- R3: `cmd_chain` is 1 on every data command except the last one of the message.
- R4: The last data command has `cmd_rpt` = 1 when `req_combined` was set and 0 otherwise. `cmd_chain` and `cmd_rpt` are never both 1.
- R5: In 7-bit mode, `addr_lo` is the address shifted left by one with bit 0 cleared, and `addr_ten` is 0.
- R6: In 10-bit mode, `addr_hi` is {5'b11110, addr[9:8], 1'b0}, `addr_lo` is addr[7:0], and `addr_ten` is 1.
- R7: A response count below the burst size ends the message with `status` = 3 (short). No further data command is issued. One command with `cmd_abort` = 1 follows if that burst was not the last, or if the message is combined; otherwise no abort is sent.
- R8: A response with `rsp_err` set ends the message with `status` = 2 (engine error). No further command is issued, including no abort.
- R9: For a write, one `data_load` strobe precedes each data command, with `data_idx` = burst index and `data_cnt` = burst size. A read produces no `data_load`.
- R10: For a read, one `data_unload` strobe follows each burst that completed in full. A write, or a burst that failed, produces none.
- R11: `busy` rises when a request is accepted. `done` is a one-cycle pulse, and `busy` is 0 on the following cycle. A successful message reports `status` = 0. `req_start` is ignored while `busy` is 1.
- R12: After reset, `busy`, `done`, `cmd_valid`, `data_load` and `data_unload` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_len | input | LEN_W | Message length in bytes |
| req_read | input | 1 | 1 = read, 0 = write |
| req_combined | input | 1 | Another message follows under repeated START |
| req_addr | input | ADDR_W | Target address |
| req_ten | input | 1 | 1 = 10-bit address mode |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| status | output | 2 | 0 ok, 1 bad request, 2 engine error, 3 short count |
| addr_lo | output | 8 | Low address byte for the engine |
| addr_hi | output | 8 | High address byte (10-bit header) |
| addr_ten | output | 1 | Address mode latched at accept |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_cnt | output | CNT_W | Burst byte count minus one |
| cmd_read | output | 1 | Direction of the burst |
| cmd_chain | output | 1 | Keep the bus, no STOP after this burst |
| cmd_rpt | output | 1 | End with repeated START instead of STOP |
| cmd_abort | output | 1 | Command is an abort |
| rsp_valid | input | 1 | Engine completion |
| rsp_err | input | 1 | Engine reports an error |
| rsp_cnt | input | CNT_W+1 | Bytes actually moved |
| data_load | output | 1 | Buffer: load the burst before the command |
| data_unload | output | 1 | Buffer: take the read burst |
| data_idx | output | LEN_W | Burst index |
| data_cnt | output | CNT_W+1 | Burst size in bytes |

## Verification
The hardest case to reach is a short count on a burst that is not the last of a long combined or plain message. Only there do the abort decision, the missing later bursts and the suppressed unload strobes all show together. The bench's engine model takes a chosen failing burst index and a failure kind. A sweep walks the failure across every burst of a three-burst message, in both directions and both combined settings. It also stalls `cmd_ready` on alternate runs, so that commands are held across wait cycles.

// File: rtl/chunk_pkg.sv
// Shared types for the chunked I2C transfer sequencer.
// Assumes nothing beyond a 2-bit status encoding known to the client.
package chunk_pkg;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_BAD_REQ = 2'd1,
        XS_ENGINE  = 2'd2,
        XS_SHORT   = 2'd3
    } xfer_status_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PREP,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_POST,
        SQ_ABORT,
        SQ_DONE
    } seq_state_e;

endpackage

// File: rtl/chunk_addr_gen.sv
// Target address former and validator.
// Builds the low/high address bytes the engine sends and flags legal
// addresses. Assumes ADDR_W >= 10; the read/write bit is added by the engine.
module chunk_addr_gen #(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ten,
    output logic [7:0]        lo,
    output logic [7:0]        hi,
    output logic              ok
);

    // Legal range and byte forming for both address modes
    always_comb begin
        if (ten) begin
            ok = ((addr >> 10) == '0);
            lo = addr[7:0];
        end else begin
            ok = ((addr >> 7) == '0);
            lo = {addr[6:0], 1'b0};
        end
        hi = {5'b11110, addr[9:8], 1'b0};
    end

endmodule

// File: rtl/chunk_calc.sv
// Burst size and last-burst detection for the remaining byte count.
// Assumes remain is non-zero whenever the result is used.
module chunk_calc #(
    parameter int LEN_W = 8,
    parameter int BURST = 4
) (
    input  logic [LEN_W-1:0]            remain,
    output logic [$clog2(BURST):0]      count,
    output logic                        last
);

    localparam int CNT_W = $clog2(BURST);
    localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST);

    // The last burst carries whatever remains; others are full
    always_comb begin
        last  = (remain <= BURST_L);
        count = last ? remain[CNT_W:0] : (CNT_W+1)'(BURST);
    end

endmodule

// File: rtl/i2c_chunk_seq.sv
// Chunked I2C master transfer sequencer (top).
// Accepts one message, validates it, forms the address bytes, and issues
// it to a burst-limited byte engine as a chain of commands. Assumes the
// engine answers each data command with exactly one response and answers
// no response to an abort command.
module i2c_chunk_seq
    import chunk_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 11,
    parameter int BURST  = 4,
    localparam int CNT_W = $clog2(BURST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_read,
    input  logic              req_combined,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ten,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [7:0]        addr_lo,
    output logic [7:0]        addr_hi,
    output logic              addr_ten,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CNT_W-1:0]  cmd_cnt,
    output logic              cmd_read,
    output logic              cmd_chain,
    output logic              cmd_rpt,
    output logic              cmd_abort,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [CNT_W:0]    rsp_cnt,
    output logic              data_load,
    output logic              data_unload,
    output logic [LEN_W-1:0]  data_idx,
    output logic [CNT_W:0]    data_cnt
);

    localparam logic [LEN_W-1:0] STEP = LEN_W'(BURST);

    seq_state_e       state_q;
    xfer_status_e     status_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] idx_q;
    logic             rd_q;
    logic             comb_q;
    logic [7:0]       lo_d, hi_d;
    logic             addr_ok;
    logic             req_ok;
    logic [CNT_W:0]   burst_cnt;
    logic             burst_last;

    chunk_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .addr (req_addr),
        .ten  (req_ten),
        .lo   (lo_d),
        .hi   (hi_d),
        .ok   (addr_ok)
    );

    chunk_calc #(.LEN_W(LEN_W), .BURST(BURST)) u_calc (
        .remain (remain_q),
        .count  (burst_cnt),
        .last   (burst_last)
    );

    // A request is legal when its address fits the mode and it has bytes
    always_comb req_ok = addr_ok && (req_len != '0);

    // Sequencer state, burst bookkeeping and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            status_q <= XS_OK;
            remain_q <= '0;
            idx_q    <= '0;
            rd_q     <= 1'b0;
            comb_q   <= 1'b0;
            addr_lo  <= '0;
            addr_hi  <= '0;
            addr_ten <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (req_start) begin
                        if (!req_ok) begin
                            status_q <= XS_BAD_REQ;
                            state_q  <= SQ_DONE;
                        end else begin
                            remain_q <= req_len;
                            idx_q    <= '0;
                            rd_q     <= req_read;
                            comb_q   <= req_combined;
                            addr_lo  <= lo_d;
                            addr_hi  <= hi_d;
                            addr_ten <= req_ten;
                            state_q  <= SQ_PREP;
                        end
                    end
                end
                SQ_PREP:  state_q <= SQ_ISSUE;
                SQ_ISSUE: if (cmd_ready) state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            status_q <= XS_ENGINE;
                            state_q  <= SQ_DONE;
                        end else if (rsp_cnt != burst_cnt) begin
                            status_q <= XS_SHORT;
                            state_q  <= (!burst_last || comb_q) ? SQ_ABORT : SQ_DONE;
                        end else begin
                            state_q <= SQ_POST;
                        end
                    end
                end
                SQ_POST: begin
                    if (burst_last) begin
                        status_q <= XS_OK;
                        state_q  <= SQ_DONE;
                    end else begin
                        remain_q <= remain_q - STEP;
                        idx_q    <= idx_q + 1'b1;
                        state_q  <= SQ_PREP;
                    end
                end
                SQ_ABORT: if (cmd_ready) state_q <= SQ_DONE;
                SQ_DONE:  state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    // Command, strobe and status outputs decoded from the state
    always_comb begin
        busy        = (state_q != SQ_IDLE);
        done        = (state_q == SQ_DONE);
        status      = status_q;
        cmd_valid   = (state_q == SQ_ISSUE) || (state_q == SQ_ABORT);
        cmd_abort   = (state_q == SQ_ABORT);
        cmd_read    = rd_q;
        cmd_cnt     = cmd_abort ? '0 : CNT_W'(burst_cnt - 1'b1);
        cmd_chain   = (state_q == SQ_ISSUE) && !burst_last;
        cmd_rpt     = (state_q == SQ_ISSUE) && burst_last && comb_q;
        data_load   = (state_q == SQ_PREP) && !rd_q;
        data_unload = (state_q == SQ_POST) && rd_q;
        data_idx    = idx_q;
        data_cnt    = burst_cnt;
    end

endmodule

// File: rtl/i2c_chunk_seq_chk.sv
// Protocol checker for the chunked transfer sequencer, bound to the top.
// Assumes only the port-level contract documented in the brief.
module i2c_chunk_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_cnt,
    input logic       cmd_chain,
    input logic       cmd_rpt,
    input logic       cmd_abort,
    input logic       cmd_read,
    input logic       data_load,
    input logic       data_unload,
    input logic [7:0] addr_hi,
    input logic       addr_ten
);

    // R2: a command offered but not taken stays unchanged
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_cnt)
            && $stable(cmd_chain) && $stable(cmd_rpt) && $stable(cmd_abort)));

    // R4: chain and repeated START never together
    assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !(cmd_chain && cmd_rpt));

    // R7: an abort carries no chain or repeated-START flag
    assert_abort_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_abort) |-> !(cmd_chain || cmd_rpt));

    // R11: done is a single-cycle pulse and the block goes idle after it
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R12: nothing is offered or strobed while idle
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cmd_valid || data_load || data_unload));

    // R9: loads only on writes
    assert_load_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |-> !cmd_read);

    // R10: unloads only on reads
    assert_unload_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_unload |-> cmd_read);

    // R6: a 10-bit header always has the fixed top pattern
    assert_ten_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ten |-> (addr_hi[7:3] == 5'b11110 && !addr_hi[0]));

endmodule

bind i2c_chunk_seq i2c_chunk_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_cnt     (2'(cmd_cnt)),
    .cmd_chain   (cmd_chain),
    .cmd_rpt     (cmd_rpt),
    .cmd_abort   (cmd_abort),
    .cmd_read    (cmd_read),
    .data_load   (data_load),
    .data_unload (data_unload),
    .addr_hi     (addr_hi),
    .addr_ten    (addr_ten)
);

// File: tb/sim_i2c_chunk_seq.sv
module sim_i2c_chunk_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [7:0]  req_len = '0;
    logic        req_read = 1'b0;
    logic        req_combined = 1'b0;
    logic [10:0] req_addr = '0;
    logic        req_ten = 1'b0;
    logic        busy, done;
    logic [1:0]  status;
    logic [7:0]  addr_lo, addr_hi;
    logic        addr_ten;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [1:0]  cmd_cnt;
    logic        cmd_read, cmd_chain, cmd_rpt, cmd_abort;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [2:0]  rsp_cnt = '0;
    logic        data_load, data_unload;
    logic [7:0]  data_idx;
    logic [2:0]  data_cnt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    i2c_chunk_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
        .req_read(req_read), .req_combined(req_combined), .req_addr(req_addr),
        .req_ten(req_ten), .busy(busy), .done(done), .status(status),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_ten(addr_ten),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cnt(cmd_cnt),
        .cmd_read(cmd_read), .cmd_chain(cmd_chain), .cmd_rpt(cmd_rpt),
        .cmd_abort(cmd_abort), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_cnt(rsp_cnt), .data_load(data_load), .data_unload(data_unload),
        .data_idx(data_idx), .data_cnt(data_cnt)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // kind: 0 none, 1 short count, 2 engine error at burst fail_at
    task automatic run_xfer(input int len, input bit rd, input bit comb,
                            input int addr, input bit ten, input int fail_at,
                            input int kind, input bit stall, input bit poke);
        int nch, last_cnt, cyc, ncmd, naborts, nloads, nunloads, flderr;
        int exp_cmds, exp_abort, exp_status, exp_unl;
        bit legal, pend, pend_err, fin;
        int pend_cnt;
        legal = (len > 0) && (addr <= 'h3FF) && (ten || addr <= 'h7F);
        nch = (len + 3) / 4;
        ncmd = 0; naborts = 0; nloads = 0; nunloads = 0; flderr = 0;
        pend = 0; pend_err = 0; pend_cnt = 0; fin = 0; cyc = 0;
        @(negedge clk);
        req_len = 8'(len); req_read = rd; req_combined = comb;
        req_addr = 11'(addr); req_ten = ten; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (!fin && cyc < 2000) begin
            cyc++;
            req_start = (poke && cyc == 4);   // R11: ignored while busy
            if (poke && cyc == 4) req_len = 8'd1;
            cmd_ready = stall ? (cyc % 3 != 1) : 1'b1;
            rsp_valid = pend; rsp_err = pend_err; rsp_cnt = 3'(pend_cnt);
            pend = 0;
            if (data_load) begin
                last_cnt = (ncmd == nch - 1) ? len - 4 * ncmd : 4;
                if (int'(data_idx) != ncmd || int'(data_cnt) != last_cnt) flderr++;
                nloads++;
            end
            if (data_unload) begin
                if (int'(data_idx) != ncmd - 1) flderr++;
                nunloads++;
            end
            if (cmd_valid && cmd_ready) begin
                if (cmd_abort) naborts++;
                else begin
                    last_cnt = (ncmd == nch - 1) ? len - 4 * ncmd : 4;
                    if (int'(cmd_cnt) != last_cnt - 1) flderr++;               // R2
                    if (cmd_chain != (ncmd != nch - 1)) flderr++;              // R3
                    if (cmd_rpt != (ncmd == nch - 1 && comb)) flderr++;        // R4
                    if (cmd_read != rd) flderr++;
                    if (!rd && nloads != ncmd + 1) flderr++;                   // R9
                    pend = 1;
                    pend_err = (kind == 2 && ncmd == fail_at);
                    pend_cnt = (kind == 1 && ncmd == fail_at) ? last_cnt - 1 : last_cnt;
                    ncmd++;
                end
            end
            if (done) fin = 1;
            else @(negedge clk);
        end
        req_start = 1'b0; rsp_valid = 1'b0;
        if (!legal) begin
            exp_cmds = 0; exp_abort = 0; exp_status = 1; exp_unl = 0;
        end else if (kind != 0) begin
            exp_cmds = fail_at + 1;
            exp_abort = (kind == 1 && (fail_at != nch - 1 || comb)) ? 1 : 0;
            exp_status = (kind == 1) ? 3 : 2;
            exp_unl = rd ? fail_at : 0;
        end else begin
            exp_cmds = nch; exp_abort = 0; exp_status = 0; exp_unl = rd ? nch : 0;
        end
        chk(fin, "R11 done seen", fin, 1);
        chk(int'(status) == exp_status, "R1/R7/R8/R11 status", status, exp_status);
        chk(ncmd == exp_cmds, "R2 data command count", ncmd, exp_cmds);
        chk(naborts == exp_abort, "R7/R8 abort count", naborts, exp_abort);
        chk(nloads == (rd ? 0 : exp_cmds), "R9 load strobes", nloads, rd ? 0 : exp_cmds);
        chk(nunloads == exp_unl, "R10 unload strobes", nunloads, exp_unl);
        chk(flderr == 0, "R2/R3/R4/R9 command fields", flderr, 0);
        if (legal) begin
            if (ten) begin
                chk(addr_ten && addr_lo == 8'(addr), "R6 low byte", addr_lo, addr & 'hFF);
                chk(int'(addr_hi) == ('hF0 | ((addr >> 7) & 'h6)), "R6 header", addr_hi,
                    'hF0 | ((addr >> 7) & 'h6));
            end else begin
                chk(!addr_ten && int'(addr_lo) == ((addr << 1) & 'hFF), "R5 low byte",
                    addr_lo, (addr << 1) & 'hFF);
            end
        end
        @(negedge clk);
        chk(!busy && !done, "R11 idle after done", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !cmd_valid && !data_load && !data_unload,
            "R12 reset outputs", busy, 0);
        rst_n = 1'b1;
        // Full sweep: length x direction x combined, alternating address mode
        for (int len = 1; len <= 13; len++)
            for (int m = 0; m < 4; m++)
                run_xfer(len, m[0], m[1], (len * 37 + m * 101) & (len[0] ? 'h3FF : 'h7F),
                         len[0], -1, 0, (len + m) % 2 == 1, m == 1 && len > 4);
        // Short count and engine error walked across every burst
        for (int f = 0; f < 3; f++)
            for (int m = 0; m < 4; m++) begin
                run_xfer(10, m[0], m[1], 'h2A5, 1'b1, f, 1, m[0], 1'b0);
                run_xfer(9, m[0], m[1], 'h55, 1'b0, f, 2, m[1], 1'b0);
            end
        // Rejected requests and boundary addresses (R1, R5, R6)
        run_xfer(0, 0, 0, 'h10, 0, -1, 0, 0, 0);
        run_xfer(3, 0, 0, 'h80, 0, -1, 0, 0, 0);
        run_xfer(3, 1, 0, 'h400, 1, -1, 0, 0, 0);
        run_xfer(2, 0, 0, 'h7F, 0, -1, 0, 0, 0);
        run_xfer(2, 1, 1, 'h3FF, 1, -1, 0, 0, 0);
        run_xfer(255, 0, 1, 'h300, 1, -1, 0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule